// File: doc/BRIEF.md
# Iterative DES Key Search Engine

This engine runs a brute-force key search over a contiguous range of DES keys. It is given a known 64-bit plaintext block, the 64-bit ciphertext that block should encrypt to, a 56-bit first candidate key and a number of candidates to try. It then encrypts the plaintext under each candidate in turn and compares every result with the ciphertext. The first candidate that reproduces the ciphertext is reported. If no candidate matches, the engine reports that the range is exhausted.

The datapath computes one DES round per clock. The 28-bit key halves rotate on the fly, so the engine stores no subkeys. Each candidate therefore occupies 16 round cycles and one compare cycle. A controller hands out ranges by pulsing `start` while `busy` is low. It then waits for `done` and reads `found`, `found_key` and `keys_tried`.

Top module: `des_key_search`

## Requirements
- R1: After reset, `busy`, `done` and `found` are low, and `keys_tried` and `found_key` are zero.
- R2: A `start` pulse with a nonzero `key_count`, sampled while `busy` is low, raises `busy` at the next edge. The same edge clears `done`, `found`, `found_key` and `keys_tried`, and latches `plaintext`, `ciphertext`, `start_key` and `key_count`.
- R3: Each candidate is encrypted with standard DES. The 64-bit key is formed by writing the 56-bit candidate, most significant bit first, seven bits at a time into the upper seven bits of each byte. The low bit of each byte is a parity position and has no effect.
- R4: Candidate i, for i = 0 .. key_count-1, is `start_key + i` modulo 2^56. Candidates are tried in increasing i, and the count wraps from all ones to zero.
- R5: Each candidate takes 17 cycles. `keys_tried` increases by one at edges 17, 34, 51 and so on after the accepting edge.
- R6: On the first candidate whose encryption equals `ciphertext`, `found` and `done` rise and `busy` falls at the same edge, and `found_key` holds that candidate. No later candidate is tried.
- R7: If no candidate matches, `done` rises with `found` low and `busy` falls 17*key_count cycles after the accepting edge, with `keys_tried` equal to `key_count`.
- R8: A `start` with `key_count` zero sets `done` at the next edge, with `found` low and `keys_tried` zero. `busy` never rises.
- R9: A `start` pulse while `busy` is high is ignored. Changes to the data inputs during a search do not alter it.
- R10: `done`, `found`, `found_key` and `keys_tried` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new search |
| plaintext | input | 64 | Known plaintext block |
| ciphertext | input | 64 | Target ciphertext block |
| start_key | input | 56 | First candidate key |
| key_count | input | CNT_W | Number of candidates to try |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished |
| found | output | 1 | A matching key was found |
| found_key | output | 56 | The matching candidate |
| keys_tried | output | CNT_W | Candidates completed so far |

## Verification
The bench builds the engine with `CNT_W` set to 8, which keeps the ranges short. That count width still reaches a zero-length range, a hit on the first and on the last candidate, and a run of candidates that wraps past the top of the 56-bit key space. Three published DES plaintext/ciphertext/key triples serve as targets. The start key is offset from the known key so that the hit lands at a chosen index, or just outside the range to force exhaustion. A behavioural timing model predicts `busy`, `done`, `found`, `found_key` and `keys_tried` on every clock. One run also fires `start` with different data in the middle of a search.

// File: rtl/des_key_search.sv
module des_key_search #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      plaintext,
  input  logic [63:0]      ciphertext,
  input  logic [55:0]      start_key,
  input  logic [CNT_W-1:0] key_count,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [55:0]      found_key,
  output logic [CNT_W-1:0] keys_tried
);

  localparam int ROUNDS  = 16;
  localparam int RND_W   = $clog2(ROUNDS + 1);
  localparam bit [15:0] TWO_STEP = 16'h7EFC;

  localparam int PC1_T [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
                                10,2,59,51,43,35,27,19,11,3,60,52,44,36,
                                63,55,47,39,31,23,15,7,62,54,46,38,30,22,
                                14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PC2_T [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
                                23,19,12,4,26,8,16,7,27,20,13,2,
                                41,52,31,37,47,55,30,40,51,45,33,48,
                                44,49,39,56,34,53,46,42,50,36,29,32};
  localparam int P_T [32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
                              2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};

  localparam bit [3:0] SB1 [64] = '{14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
                                    0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
                                    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
                                    15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam bit [3:0] SB2 [64] = '{15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
                                    3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
                                    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
                                    13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam bit [3:0] SB3 [64] = '{10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
                                    13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
                                    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
                                    1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam bit [3:0] SB4 [64] = '{7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
                                    13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
                                    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
                                    3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam bit [3:0] SB5 [64] = '{2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
                                    14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
                                    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
                                    11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam bit [3:0] SB6 [64] = '{12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
                                    10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
                                    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
                                    4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam bit [3:0] SB7 [64] = '{4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
                                    13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
                                    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
                                    6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam bit [3:0] SB8 [64] = '{13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
                                    1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
                                    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
                                    2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  function automatic logic [63:0] widen_key(input logic [55:0] k);
    logic [63:0] y;
    for (int b = 0; b < 8; b++) y[63-8*b -: 8] = {k[55-7*b -: 7], 1'b0};
    return y;
  endfunction

  function automatic logic [55:0] perm_pc1(input logic [63:0] k);
    logic [55:0] y;
    for (int i = 0; i < 56; i++) y[55-i] = k[64-PC1_T[i]];
    return y;
  endfunction

  function automatic logic [47:0] perm_pc2(input logic [55:0] k);
    logic [47:0] y;
    for (int i = 0; i < 48; i++) y[47-i] = k[56-PC2_T[i]];
    return y;
  endfunction

  function automatic int ip_src(input int o);
    int r, c;
    r = o / 8;
    c = o % 8;
    return ((r < 4) ? 2*r + 2 : 2*r - 7) + 8*(7 - c);
  endfunction

  function automatic logic [63:0] perm_ip(input logic [63:0] x);
    logic [63:0] y;
    for (int o = 0; o < 64; o++) y[63-o] = x[64-ip_src(o)];
    return y;
  endfunction

  function automatic logic [63:0] perm_fp(input logic [63:0] x);
    logic [63:0] y;
    for (int o = 0; o < 64; o++) y[64-ip_src(o)] = x[63-o];
    return y;
  endfunction

  function automatic logic [3:0] sbox(input int n, input logic [5:0] a);
    logic [5:0] ix;
    ix = {a[5], a[0], a[4:1]};
    case (n)
      0: return SB1[ix];
      1: return SB2[ix];
      2: return SB3[ix];
      3: return SB4[ix];
      4: return SB5[ix];
      5: return SB6[ix];
      6: return SB7[ix];
      default: return SB8[ix];
    endcase
  endfunction

  function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] t;
    logic [31:0] s, y;
    int src;
    for (int g = 0; g < 8; g++)
      for (int j = 0; j < 6; j++) begin
        src = 4*g + j;
        if (src == 0) src = 32;
        if (src == 33) src = 1;
        t[47-(6*g+j)] = r[32-src];
      end
    t = t ^ k;
    for (int g = 0; g < 8; g++) s[31-4*g -: 4] = sbox(g, t[47-6*g -: 6]);
    for (int i = 0; i < 32; i++) y[31-i] = s[32-P_T[i]];
    return y;
  endfunction

  logic [RND_W-1:0] rnd;
  logic [55:0]      cd, cur;
  logic [31:0]      lh, rh;
  logic [63:0]      pt_q, ct_q;
  logic [CNT_W-1:0] cnt_q;

  logic [27:0] c_n, d_n;
  logic        two;
  logic        last_rnd, hit, last_key;

  assign two      = TWO_STEP[rnd[3:0]];
  assign c_n      = two ? {cd[53:28], cd[55:54]} : {cd[54:28], cd[55]};
  assign d_n      = two ? {cd[25:0], cd[27:26]}  : {cd[26:0], cd[27]};
  assign last_rnd = (rnd == RND_W'(ROUNDS));
  assign hit      = (perm_fp({rh, lh}) == ct_q);
  assign last_key = (keys_tried + 1'b1) == cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      found      <= 1'b0;
      found_key  <= '0;
      keys_tried <= '0;
      rnd        <= '0;
      cd         <= '0;
      cur        <= '0;
      lh         <= '0;
      rh         <= '0;
      pt_q       <= '0;
      ct_q       <= '0;
      cnt_q      <= '0;
    end else if (start && !busy) begin
      done       <= (key_count == '0);
      busy       <= (key_count != '0);
      found      <= 1'b0;
      found_key  <= '0;
      keys_tried <= '0;
      pt_q       <= plaintext;
      ct_q       <= ciphertext;
      cnt_q      <= key_count;
      cur        <= start_key;
      rnd        <= '0;
      cd         <= perm_pc1(widen_key(start_key));
      {lh, rh}   <= perm_ip(plaintext);
    end else if (busy) begin
      if (!last_rnd) begin
        cd  <= {c_n, d_n};
        lh  <= rh;
        rh  <= lh ^ feistel(rh, perm_pc2({c_n, d_n}));
        rnd <= rnd + 1'b1;
      end else begin
        keys_tried <= keys_tried + 1'b1;
        if (hit) begin
          found     <= 1'b1;
          done      <= 1'b1;
          busy      <= 1'b0;
          found_key <= cur;
        end else if (last_key) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          cur      <= cur + 56'd1;
          cd       <= perm_pc1(widen_key(cur + 56'd1));
          {lh, rh} <= perm_ip(pt_q);
          rnd      <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/des_key_search_chk.sv
module des_key_search_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] key_count,
  input logic             busy,
  input logic             done,
  input logic             found,
  input logic [55:0]      found_key,
  input logic [CNT_W-1:0] keys_tried
);

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && key_count != '0) |=> busy && !done && !found && keys_tried == '0);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && key_count == '0) |=> done && !busy && !found && keys_tried == '0);

  p_tried_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (keys_tried == $past(keys_tried)) || (keys_tried == CNT_W'($past(keys_tried) + 1'b1)));

  p_found_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done && !busy);

  p_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done) && keys_tried >= $past(keys_tried));

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(found) && $stable(found_key) && $stable(keys_tried));

endmodule

bind des_key_search des_key_search_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_count(key_count),
  .busy(busy), .done(done), .found(found), .found_key(found_key),
  .keys_tried(keys_tried)
);

// File: tb/tb_des_key_search.sv
module tb_des_key_search;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int PER_KEY = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   plaintext = '0, ciphertext = '0;
  logic [55:0]   start_key = '0;
  logic [CW-1:0] key_count = '0;
  logic          busy, done, found;
  logic [55:0]   found_key;
  logic [CW-1:0] keys_tried;

  des_key_search #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
    .ciphertext(ciphertext), .start_key(start_key), .key_count(key_count),
    .busy(busy), .done(done), .found(found), .found_key(found_key),
    .keys_tried(keys_tried)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit reported = 0;
  bit model_on = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [55:0] strip(input logic [63:0] k);
    logic [55:0] y;
    for (int b = 0; b < 8; b++) y[55-7*b -: 7] = k[63-8*b -: 7];
    return y;
  endfunction

  // behavioural timing model
  bit          m_busy, m_done, m_found;
  logic [55:0] m_fkey, m_key;
  int          m_cyc, m_tried, m_n, m_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_found = 0; m_fkey = '0; m_tried = 0; m_cyc = 0;
    end else if (start && !m_busy) begin
      m_done = 0; m_found = 0; m_tried = 0; m_fkey = '0; m_n = int'(key_count);
      if (m_n == 0) m_done = 1;
      else begin m_busy = 1; m_cyc = 0; end
    end else if (m_busy) begin
      m_cyc++;
      if (m_cyc == PER_KEY) begin
        m_cyc = 0;
        m_tried++;
        if (m_tried - 1 == m_hit) begin
          m_found = 1; m_done = 1; m_busy = 0; m_fkey = m_key;
        end else if (m_tried == m_n) begin
          m_done = 1; m_busy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(busy == m_busy, "R2 R5 busy per cycle", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R6 R7 R10 done per cycle", 64'(done), 64'(m_done));
      chk(found == m_found, "R6 found per cycle", 64'(found), 64'(m_found));
      chk(int'(keys_tried) == m_tried, "R5 keys_tried per cycle", 64'(keys_tried), 64'(m_tried));
      chk(found_key == m_fkey, "R6 R10 found_key per cycle", 64'(found_key), 64'(m_fkey));
    end
  end

  task automatic search(input logic [63:0] p, input logic [63:0] c, input logic [55:0] sk,
                        input int n, input int hit, input logic [55:0] hk,
                        input bit poke, input string req);
    int cyc;
    @(negedge clk);
    plaintext = p; ciphertext = c; start_key = sk; key_count = CW'(n);
    m_hit = hit; m_key = hk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      if (poke && cyc == 20) begin
        plaintext = ~p; ciphertext = '0; start_key = '0; key_count = '0; start = 1'b1;
      end else if (poke && cyc == 21) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(cyc == PER_KEY * ((hit >= 0) ? hit + 1 : n), {req, " R5 busy length"},
        64'(cyc), 64'(PER_KEY * ((hit >= 0) ? hit + 1 : n)));
    repeat (2) @(negedge clk);
    chk(done == 1'b1, {req, " done held R10"}, 64'(done), 64'd1);
    chk(found == (hit >= 0), {req, " found"}, 64'(found), 64'(hit >= 0));
    chk(int'(keys_tried) == ((hit >= 0) ? hit + 1 : n), {req, " keys_tried"},
        64'(keys_tried), 64'((hit >= 0) ? hit + 1 : n));
    if (hit >= 0) chk(found_key == hk, {req, " found_key R3"}, 64'(found_key), 64'(hk));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [63:0] pa, ca, pb, cb, pc, cc;
    logic [55:0] ka, kb, kc;
    pa = 64'h0123456789ABCDEF; ca = 64'h85E813540F0AB405; ka = strip(64'h133457799BBCDFF1);
    pb = 64'h0;                cb = 64'h8CA64DE9C1B123A7; kb = 56'h0;
    pc = 64'h8787878787878787; cc = 64'h0;                kc = strip(64'h0E329232EA6D0D73);

    repeat (3) @(negedge clk);
    chk(!busy && !done && !found, "R1 flags in reset", {61'd0, busy, done, found}, 64'd0);
    chk(keys_tried == '0 && found_key == '0, "R1 counters in reset", 64'(found_key), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !found, "R1 flags after reset", {61'd0, busy, done, found}, 64'd0);
    model_on = 1;

    search(pa, ca, ka - 56'd3, 10, 3, ka, 0, "R6 hit mid range");
    search(pb, cb, kb, 1, 0, kb, 0, "R6 hit on first key");
    search(pa, ca, ka + 56'd1, 3, -1, '0, 0, "R7 exhaustion");
    search(pa, ca, ka - 56'd4, 5, 4, ka, 0, "R4 hit on last key");
    search(pc, cc, kc - 56'd2, 6, 2, kc, 0, "R3 second vector");
    search(pb, cb, 56'hFF_FFFF_FFFF_FFFF, 3, 1, 56'h0, 0, "R4 wrap past top");
    search(pa, ca, ka - 56'd3, 10, 3, ka, 1, "R9 start while busy");
    search(pa, ca, ka, 0, -1, '0, 0, "R8 zero count");
    chk(!busy, "R8 busy stays low", 64'(busy), 64'd0);
    search(pa, ca, ka - 56'd1, 4, 1, ka, 0, "R2 restart after zero count");

    repeat (5) @(negedge clk);
    report();
  end
endmodule